// File: doc/BRIEF.md
# Windowed Clock Frequency Monitor

This block watches a fast main clock by timing it against a slower reference. The reference comes from an on-chip RC oscillator and is divided by 256, 512 or 1024. The divided reference crosses into the main-clock domain through a synchroniser. Between two of its rising edges, the block counts main-clock cycles. It checks each finished count against a programmable lower and upper limit. A count outside those limits is treated as a frequency anomaly.

An anomaly raises a sticky flag and freezes the offending count so software can inspect it. If both enables are set, the anomaly also drives a reset request toward the system reset logic. Software configures the block through a small word-wide register port: a control word, two 16-bit limits, a status word that clears on read, and the read-only captured count.

A software-reset input restarts the measurement and drops the flag. It leaves every configuration register and the captured count untouched. Only the hardware reset initialises those.

Top module: `clk_freq_window_mon`

## Requirements
- R1: After hardware reset the registers read back as follows:
  - address 0, control: 0x001C. Bit 0 is the monitor enable, bit 1 the reset-request enable, bits 4:2 the divider code.
  - address 1, status: 0. Bit 0 is the anomaly flag.
  - address 2, upper limit: 0xFFFF.
  - address 3, lower limit: 0x0000.
  - address 4, captured count: 0.
  - `anomaly` and `rst_req` are low.
- R2: Divider code 101 makes one measurement span 256 reference cycles, 110 spans 512 and 111 spans 1024. The measured value is the number of main-clock rising edges in that span.
- R3: A control write carrying a divider code from 000 to 100 leaves the stored divider code unchanged, while the two enable bits still take the written values.
- R4: A measurement starts at a synchronised rising edge of the divided reference and ends at the next one. The first edge after enabling only starts counting and is never compared. The counter saturates at 0xFFFF instead of wrapping.
- R5: A finished count sets the anomaly flag when it is below the lower limit or above the upper limit. A count equal to either limit does not set it.
- R6: While the flag is clear, each finished count is stored in the count register. While the flag is set, the stored count keeps the value that caused the anomaly.
- R7: Reading the status address returns the flag in bit 0 and clears it, unless a new anomaly is detected in the same cycle.
- R8: `rst_req` is high exactly when the monitor enable, the reset-request enable and the anomaly flag are all 1.
- R9: Pulling `soft_rst_n` low clears the flag and restarts measurement, but keeps the control, both limits and the captured count.
- R10: Writes to the status and count addresses have no effect on the flag or on the captured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Monitored main clock; all registers except the divider run on it |
| rst_n | input | 1 | Synchronous active-low hardware reset, held for several reference cycles |
| soft_rst_n | input | 1 | Synchronous active-low software reset of the measurement state only |
| ref_clk | input | 1 | Undivided RC reference clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag when reading status) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, combinational |
| anomaly | output | 1 | Sticky frequency-anomaly flag |
| rst_req | output | 1 | Reset request toward the system reset logic |

## Verification
Assertions check several properties on every cycle:
- the divider code never holds an invalid value;
- synchronised edge pulses last one cycle;
- the counter stays pinned at its ceiling;
- an out-of-window count always raises the flag, and nothing else does;
- the captured count never moves while the flag is set;
- a status read or software reset drops the flag;
- writes to the count address leave it alone.

Only the bench's scenarios can show that a count equals the true number of main cycles in 256, 512 or 1024 reference periods, and how the limits behave at equality. The same holds for the first edge after enabling, which must only start counting, and for a long stall of the reference ending in a saturated, frozen count.

// File: rtl/clkmon_pkg.sv
// Shared constants for the windowed clock frequency monitor.
// Assumes a word-addressed register port with 3-bit addresses.
package clkmon_pkg;
    localparam int ADDR_W   = 3;
    localparam int SEL_W    = 3;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_UPPER = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOWER = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

    // Control word bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RQ_BIT  = 1;
    localparam int CTRL_DIV_LSB = 2;

    // Divider code range: lowest legal code selects the smallest ratio
    localparam logic [SEL_W-1:0] DIV_CODE_MIN = 3'd5;
    localparam logic [SEL_W-1:0] DIV_CODE_RST = 3'd7;
endpackage

// File: rtl/clkmon_ref_div.sv
// Reference divider, running on the RC reference clock.
// A free-running binary counter is tapped at one of STEPS bit positions;
// the lowest legal code picks a divide-by-2**MIN_LOG2 output.
// Assumes div_sel is quasi-static (changed only while monitoring is off)
// and that rst_n is held over several reference cycles.
module clkmon_ref_div #(
    parameter int SEL_W    = 3,
    parameter int MIN_CODE = 5,
    parameter int MIN_LOG2 = 8,
    parameter int STEPS    = 3
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             div_clk
);
    localparam int DCW = MIN_LOG2 + STEPS - 1;

    logic [DCW-1:0]   ref_cnt;
    logic [STEPS-1:0] taps;
    logic [SEL_W-1:0] step;
    logic             tap_sel;

    // Free-running reference cycle counter
    always_ff @(posedge ref_clk) begin
        if (!rst_n) ref_cnt <= '0;
        else        ref_cnt <= ref_cnt + 1'b1;
    end

    // One tap per selectable ratio
    generate
        for (genvar k = 0; k < STEPS; k++) begin : g_tap
            assign taps[k] = ref_cnt[MIN_LOG2 - 1 + k];
        end
    endgenerate

    assign step = div_sel - SEL_W'(MIN_CODE);

    // Pick the tap addressed by the divider code
    always_comb begin
        tap_sel = 1'b0;
        for (int k = 0; k < STEPS; k++) begin
            if (int'(step) == k) tap_sel = taps[k];
        end
    end

    // Register the output so the crossing signal is glitch free
    always_ff @(posedge ref_clk) begin
        if (!rst_n) div_clk <= 1'b0;
        else        div_clk <= tap_sel;
    end

    AST_DIV_CODE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        div_sel >= SEL_W'(MIN_CODE)); // R3
endmodule

// File: rtl/clkmon_edge_sync.sv
// Brings the divided reference into the main-clock domain through a
// STAGES-deep synchroniser and emits a one-cycle pulse per rising edge.
// Assumes the input stays high and low for more than STAGES+1 main cycles.
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_p
);
    logic [STAGES:0] sh;

    // Synchroniser chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise_p = sh[STAGES-1] & ~sh[STAGES];

    AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> !rise_p); // R4
endmodule

// File: rtl/clkmon_measure.sv
// Period counter and window comparator in the main-clock domain.
// Counts cycles between reference edge pulses, compares each completed
// count with the limits, holds a sticky flag and the captured count.
// Assumes lo <= hi is maintained by software; the cap register is only
// initialised by the hardware reset.
module clkmon_measure #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_n,
    input  logic             en,
    input  logic             edge_p,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    input  logic             flag_clr,
    output logic             flag,
    output logic [CNT_W-1:0] cap
);
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             restart;
    logic             outside;
    logic             done;
    logic             hit;

    assign restart = !soft_rst_n || !en;
    assign outside = (cnt < lo) || (cnt > hi);
    assign done    = edge_p && armed && !restart;
    assign hit     = done && outside;

    // Arm on the first edge, then count with saturation between edges
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (edge_p) begin
            armed <= 1'b1;
            cnt   <= CNT_W'(1);
        end else if (armed && cnt != '1) begin
            cnt   <= cnt + 1'b1;
        end
    end

    // Sticky anomaly flag: set wins over a read clear
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) flag <= 1'b0;
        else if (hit)              flag <= 1'b1;
        else if (flag_clr)         flag <= 1'b0;
    end

    // Captured count, frozen while an anomaly is pending
    always_ff @(posedge clk) begin
        if (!rst_n)              cap <= '0;
        else if (done && !flag)  cap <= cnt;
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt == '1 && !edge_p && !restart) |=> (cnt == '1)); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_p && armed && soft_rst_n && en && ((cnt < lo) || (cnt > hi))) |=> flag); // R5
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(edge_p && armed)) |=> !flag); // R5
    AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> $stable(cap)); // R6
    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> (!flag && !armed)); // R9
endmodule

// File: rtl/clk_freq_window_mon.sv
// Top of the windowed clock frequency monitor: register file, reference
// divider, edge synchroniser and measurement unit.
// Assumes configuration changes are made with monitoring disabled and that
// rst_n (synchronous, active low) is held over several reference cycles.
module clk_freq_window_mon #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 8,
    parameter int DIV_STEPS   = 3
) (
    input  logic                         clk_main,
    input  logic                         rst_n,
    input  logic                         soft_rst_n,
    input  logic                         ref_clk,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [clkmon_pkg::ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]             reg_wdata,
    output logic [CNT_W-1:0]             reg_rdata,
    output logic                         anomaly,
    output logic                         rst_req
);
    import clkmon_pkg::*;

    logic             mon_en;
    logic             rq_en;
    logic [SEL_W-1:0] div_sel;
    logic [CNT_W-1:0] win_hi;
    logic [CNT_W-1:0] win_lo;
    logic [CNT_W-1:0] cap_cnt;
    logic [SEL_W-1:0] wr_div;
    logic             div_clk;
    logic             edge_p;
    logic             flag_clr;

    assign wr_div = reg_wdata[CTRL_DIV_LSB +: SEL_W];

    // Configuration registers; only the hardware reset initialises them
    always_ff @(posedge clk_main) begin
        if (!rst_n) begin
            mon_en  <= 1'b0;
            rq_en   <= 1'b0;
            div_sel <= DIV_CODE_RST;
            win_hi  <= '1;
            win_lo  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    mon_en <= reg_wdata[CTRL_EN_BIT];
                    rq_en  <= reg_wdata[CTRL_RQ_BIT];
                    if (wr_div >= DIV_CODE_MIN) div_sel <= wr_div;
                end
                A_UPPER: win_hi <= reg_wdata;
                A_LOWER: win_lo <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_EN_BIT]                = mon_en;
                reg_rdata[CTRL_RQ_BIT]                = rq_en;
                reg_rdata[CTRL_DIV_LSB +: SEL_W]      = div_sel;
            end
            A_STAT:  reg_rdata[0] = anomaly;
            A_UPPER: reg_rdata    = win_hi;
            A_LOWER: reg_rdata    = win_lo;
            A_COUNT: reg_rdata    = cap_cnt;
            default: ;
        endcase
    end

    assign flag_clr = reg_rd && (reg_addr == A_STAT);
    assign rst_req  = mon_en && rq_en && anomaly;

    clkmon_ref_div #(
        .SEL_W    (SEL_W),
        .MIN_CODE (int'(DIV_CODE_MIN)),
        .MIN_LOG2 (DIV_LOG2),
        .STEPS    (DIV_STEPS)
    ) u_div (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .div_clk (div_clk)
    );

    clkmon_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk_main),
        .rst_n    (rst_n),
        .async_in (div_clk),
        .rise_p   (edge_p)
    );

    clkmon_measure #(
        .CNT_W (CNT_W)
    ) u_meas (
        .clk        (clk_main),
        .rst_n      (rst_n),
        .soft_rst_n (soft_rst_n),
        .en         (mon_en),
        .edge_p     (edge_p),
        .lo         (win_lo),
        .hi         (win_hi),
        .flag_clr   (flag_clr),
        .flag       (anomaly),
        .cap        (cap_cnt)
    );

    AST_STAT_CLR: assert property (@(posedge clk_main) disable iff (!rst_n)
        (flag_clr && anomaly && !edge_p) |=> !anomaly); // R7
    AST_CNT_RO: assert property (@(posedge clk_main) disable iff (!rst_n)
        (reg_wr && reg_addr == A_COUNT && !edge_p) |=> $stable(cap_cnt)); // R10
endmodule

// File: tb/tb_clk_freq_window_mon.sv
`timescale 1ns/100ps
module tb_clk_freq_window_mon;
    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_UPPER = 3'd2,
                           A_LOWER = 3'd3, A_COUNT = 3'd4;

    typedef struct packed {
        logic [2:0]  div;
        logic [7:0]  half_ds;   // reference half period in 0.1 ns
        logic [15:0] lo;
        logic [15:0] hi;
        logic [15:0] cnt;       // expected count = ratio * Tref / 10 ns
        logic        flag;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'd5, 8'd100, 16'd0,    16'hFFFF, 16'd512,  1'b0},
        '{3'd6, 8'd100, 16'd1000, 16'd1100, 16'd1024, 1'b0},
        '{3'd7, 8'd75,  16'd1400, 16'd1700, 16'd1536, 1'b0},
        '{3'd5, 8'd125, 16'd640,  16'd700,  16'd640,  1'b0},
        '{3'd5, 8'd125, 16'd641,  16'd700,  16'd640,  1'b1},
        '{3'd5, 8'd75,  16'd300,  16'd384,  16'd384,  1'b0},
        '{3'd5, 8'd75,  16'd300,  16'd383,  16'd384,  1'b1},
        '{3'd6, 8'd125, 16'd926,  16'd1131, 16'd1280, 1'b1}
    };

    logic        clk_main, rst_n, soft_rst_n, ref_clk;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        anomaly, rst_req;

    real ref_half = 10.0;
    bit  ref_run  = 1'b1;
    int  checks   = 0;
    int  failures = 0;
    logic [15:0] d;

    clk_freq_window_mon dut (
        .clk_main(clk_main), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .ref_clk(ref_clk), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .anomaly(anomaly), .rst_req(rst_req)
    );

    initial clk_main = 1'b0;
    always #5 clk_main = ~clk_main;

    // Reference edges sit at 0.3 ns + n*2.5 ns, never on a main edge
    initial begin
        ref_clk = 1'b0;
        #0.3;
        forever begin
            #(ref_half);
            if (ref_run) ref_clk = ~ref_clk;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] v);
        @(negedge clk_main);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk_main);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        @(negedge clk_main);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk_main);
        reg_rd = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk_main);
    endtask

    function automatic logic [15:0] ctrl_w(logic en, logic rq, logic [2:0] dv);
        return {11'd0, dv, rq, en};
    endfunction

    initial begin
        repeat (195000) @(posedge clk_main);
        checks++; failures++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst_n = 1'b1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        wait_cyc(20);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        chk("R1 anomaly", anomaly, 0);
        chk("R1 rst_req", rst_req, 0);
        rd(A_CTRL, d);  chk("R1 ctrl", d, 16'h001C);
        rd(A_STAT, d);  chk("R1 status", d, 0);
        rd(A_UPPER, d); chk("R1 upper", d, 16'hFFFF);
        rd(A_LOWER, d); chk("R1 lower", d, 0);
        rd(A_COUNT, d); chk("R1 count", d, 0);

        // R2 / R5 / R6 / R8 vector table
        for (int i = 0; i < NV; i++) begin
            int p;
            p = int'(VEC[i].cnt);
            wr(A_CTRL, ctrl_w(1'b0, 1'b1, VEC[i].div));
            ref_half = real'(VEC[i].half_ds) / 10.0;
            wr(A_LOWER, VEC[i].lo);
            wr(A_UPPER, VEC[i].hi);
            rd(A_STAT, d);
            wait_cyc(2 * p + 20);
            wr(A_CTRL, ctrl_w(1'b1, 1'b1, VEC[i].div));
            wait_cyc(2 * p + 30);
            chk($sformatf("R5 vec%0d anomaly", i), anomaly, VEC[i].flag);
            chk($sformatf("R8 vec%0d rst_req", i), rst_req, VEC[i].flag);
            rd(A_COUNT, d);
            chk($sformatf("R2 R6 vec%0d count", i), d, VEC[i].cnt);
        end

        // R8: reset-request enable off while the flag stays set
        wr(A_CTRL, ctrl_w(1'b1, 1'b0, 3'd6));
        #1;
        chk("R8 rst_req with rq_en=0", rst_req, 0);
        chk("R8 flag kept", anomaly, 1);

        // R10: writes to status and count do nothing
        wr(A_STAT, 16'h0000);
        wr(A_COUNT, 16'h1234);
        #1;
        chk("R10 flag after status write", anomaly, 1);
        rd(A_COUNT, d); chk("R10 count after write", d, 16'd1280);

        // R6: count frozen while flag set, even with in-window measurements
        ref_half = 10.0;
        wait_cyc(3000);
        rd(A_COUNT, d); chk("R6 frozen count", d, 16'd1280);

        // R7: status read returns then clears the flag
        rd(A_STAT, d); chk("R7 first status read", d, 1);
        rd(A_STAT, d); chk("R7 second status read", d, 0);
        wait_cyc(2200);
        chk("R7 flag stays clear", anomaly, 0);
        rd(A_COUNT, d); chk("R6 count resumes", d, 16'd1024);

        // R9: soft reset drops flag, keeps configuration and count
        wr(A_LOWER, 16'd1100);
        wait_cyc(2200);
        chk("R9 flag before soft reset", anomaly, 1);
        @(negedge clk_main); soft_rst_n = 1'b0;
        @(negedge clk_main); soft_rst_n = 1'b1;
        #1;
        chk("R9 flag after soft reset", anomaly, 0);
        rd(A_LOWER, d); chk("R9 lower kept", d, 16'd1100);
        rd(A_UPPER, d); chk("R9 upper kept", d, 16'd1131);
        rd(A_CTRL, d);  chk("R9 ctrl kept", d, ctrl_w(1'b1, 1'b0, 3'd6));
        rd(A_COUNT, d); chk("R9 count kept", d, 16'd1024);

        // R3: illegal divider codes are not stored
        wr(A_CTRL, ctrl_w(1'b1, 1'b1, 3'b011));
        rd(A_CTRL, d); chk("R3 code 011 ignored", d, ctrl_w(1'b1, 1'b1, 3'd6));
        wr(A_CTRL, ctrl_w(1'b0, 1'b0, 3'b000));
        rd(A_CTRL, d); chk("R3 code 000 ignored", d, ctrl_w(1'b0, 1'b0, 3'd6));

        // R4: first edge after enabling only arms the counter
        wr(A_CTRL, ctrl_w(1'b0, 1'b1, 3'd5));
        wait_cyc(1200);
        ref_run = 1'b0;
        wr(A_LOWER, 16'd100);
        wr(A_UPPER, 16'hFFFE);
        rd(A_STAT, d);
        wr(A_CTRL, ctrl_w(1'b1, 1'b1, 3'd5));
        wait_cyc(50);
        ref_run = 1'b1;
        wait_cyc(2 * 512 + 40);
        chk("R4 no compare on arming edge", anomaly, 0);
        rd(A_COUNT, d); chk("R4 first full period", d, 16'd512);

        // R4: stalled reference saturates the counter
        ref_run = 1'b0;
        wait_cyc(70000);
        ref_run = 1'b1;
        wait_cyc(700);
        chk("R4 R5 saturated count flagged", anomaly, 1);
        chk("R8 rst_req on saturation", rst_req, 1);
        rd(A_COUNT, d); chk("R4 saturated count", d, 16'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule